// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns the two decode fields of an instruction word, the 6-bit primary opcode and the 6-bit function code, into the ten control signals that steer a small single-cycle processor datapath. It covers a twenty-instruction load/store subset: register arithmetic and logic operations, their immediate forms, load upper immediate, word load and store, three conditional branches, an absolute jump and a jump through a register.

The decoder holds no state and has no clock. Its outputs follow the inputs through combinational logic only, so they settle within the same cycle that the instruction word is presented. An encoding outside the supported set drives every control output to zero. That zero pattern writes no register, writes no memory, takes no branch and makes no jump, so a stray or corrupt instruction word has no architectural effect.

Top module: `ctrl_decoder`

## Requirements
- R1: With opcode 000000, function codes 100000 (add), 100010 (sub) and 101010 (slt) set wr_reg=1, dst_rd=1, wb_alu=1, b_imm=0, wr_mem=0, br_kind=00 and pc_mode=00. alu_sub is 0 for add and 1 for sub and slt. res_sel is 10 (arithmetic) for add and sub, and 01 (set-less-than) for slt.
- R2: With opcode 000000, function codes 100100, 100101, 100110 and 100111 set logic_op to 00 (AND), 01 (OR), 10 (XOR) and 11 (NOR) in that order. All four set res_sel=11 (logic), wr_reg=1, dst_rd=1, wb_alu=1, b_imm=0 and alu_sub=0.
- R3: Opcodes 001000 (addi), 001010 (slti) and 001111 (lui) set wr_reg=1, dst_rd=0, wb_alu=1 and b_imm=1. res_sel is 10, 01 and 00 respectively, and alu_sub is 1 only for slti.
- R4: Opcodes 001100, 001101 and 001110 set logic_op to 00, 01 and 10 respectively, with res_sel=11, wr_reg=1, dst_rd=0, wb_alu=1, b_imm=1 and alu_sub=0.
- R5: Opcode 100011 (load word) sets wr_reg=1, dst_rd=0, wb_alu=0 (memory data to the register input), b_imm=1, alu_sub=0, res_sel=10 and wr_mem=0.
- R6: Opcode 101011 (store word) sets wr_mem=1, wr_reg=0, b_imm=1, alu_sub=0 and res_sel=10.
- R7: Opcodes 000100, 000101 and 000001 set br_kind to 01, 10 and 11 respectively. They write no register or memory and set pc_mode=00.
- R8: Opcode 000010 sets pc_mode=01 (jump). Opcode 000000 with function code 001000 sets pc_mode=10 (jump register). Neither writes a register or memory or sets a branch kind.
- R9: Any opcode/function pair not listed in R1 to R8 drives all fourteen output bits to 0.
- R10: For every opcode other than 000000, the function code has no effect on any output.
- R11: For every input, pc_mode is never 11, wr_reg and wr_mem are never both 1, and a nonzero br_kind or pc_mode comes with no register or memory write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_code | input | 6 | Primary opcode field of the instruction |
| fn_code | input | 6 | Function code field, significant only when op_code is 000000 |
| wr_reg | output | 1 | 1: write the register file |
| dst_rd | output | 1 | 1: destination is the rd field; 0: rt field |
| wb_alu | output | 1 | 1: ALU result to register input; 0: data memory output |
| b_imm | output | 1 | 1: ALU y operand is the sign-extended immediate; 0: rt register value |
| alu_sub | output | 1 | 1: adder subtracts; 0: adds |
| wr_mem | output | 1 | 1: write the data memory |
| logic_op | output | 2 | 00 AND, 01 OR, 10 XOR, 11 NOR |
| res_sel | output | 2 | 00 upper immediate, 01 set-less-than, 10 arithmetic, 11 logic |
| br_kind | output | 2 | 00 none, 01 equal, 10 not equal, 11 less than zero |
| pc_mode | output | 2 | 00 sequential/branch, 01 jump, 10 jump register, 11 never driven |

## Verification
Each of the twenty supported encodings is applied alone and the full fourteen-bit output word is compared, so a swapped field or a wrong code value is caught on the instruction it belongs to. An exhaustive sweep of all 4096 opcode/function pairs separates the supported set from everything else and confirms the all-zero safe pattern for the rest. A second pattern holds each nonzero opcode fixed and varies the function code over values that mean something under opcode 000000. This catches decode logic that looks at the function field when it should ignore it, including the jump-register code sharing its value with an immediate opcode.

// File: rtl/ctrl_pkg.sv
// Package: shared field widths, instruction codes and control types for the
// instruction control decoder. Assumes a 6-bit opcode and 6-bit function code.
package ctrl_pkg;

    localparam int OPC_W = 6;
    localparam int FNC_W = 6;
    localparam int SEL_W = 2;

    // primary opcodes
    localparam logic [OPC_W-1:0] OPC_SPECIAL = 6'b000000;
    localparam logic [OPC_W-1:0] OPC_BLTZ    = 6'b000001;
    localparam logic [OPC_W-1:0] OPC_J       = 6'b000010;
    localparam logic [OPC_W-1:0] OPC_BEQ     = 6'b000100;
    localparam logic [OPC_W-1:0] OPC_BNE     = 6'b000101;
    localparam logic [OPC_W-1:0] OPC_ADDI    = 6'b001000;
    localparam logic [OPC_W-1:0] OPC_SLTI    = 6'b001010;
    localparam logic [OPC_W-1:0] OPC_ANDI    = 6'b001100;
    localparam logic [OPC_W-1:0] OPC_ORI     = 6'b001101;
    localparam logic [OPC_W-1:0] OPC_XORI    = 6'b001110;
    localparam logic [OPC_W-1:0] OPC_LUI     = 6'b001111;
    localparam logic [OPC_W-1:0] OPC_LW      = 6'b100011;
    localparam logic [OPC_W-1:0] OPC_SW      = 6'b101011;

    // function codes under OPC_SPECIAL
    localparam logic [FNC_W-1:0] FNC_JR  = 6'b001000;
    localparam logic [FNC_W-1:0] FNC_ADD = 6'b100000;
    localparam logic [FNC_W-1:0] FNC_SUB = 6'b100010;
    localparam logic [FNC_W-1:0] FNC_AND = 6'b100100;
    localparam logic [FNC_W-1:0] FNC_OR  = 6'b100101;
    localparam logic [FNC_W-1:0] FNC_XOR = 6'b100110;
    localparam logic [FNC_W-1:0] FNC_NOR = 6'b100111;
    localparam logic [FNC_W-1:0] FNC_SLT = 6'b101010;

    typedef enum logic [4:0] {
        K_BAD,
        K_ADD, K_SUB, K_SLT,
        K_AND, K_OR, K_XOR, K_NOR,
        K_ADDI, K_SLTI, K_LUI,
        K_ANDI, K_ORI, K_XORI,
        K_LW, K_SW,
        K_BEQ, K_BNE, K_BLTZ,
        K_J, K_JR
    } instr_kind_e;

    typedef enum logic [SEL_W-1:0] {LOP_AND = 2'b00, LOP_OR = 2'b01, LOP_XOR = 2'b10, LOP_NOR = 2'b11} logic_op_e;
    typedef enum logic [SEL_W-1:0] {RES_LUI = 2'b00, RES_SLT = 2'b01, RES_ARITH = 2'b10, RES_LOGIC = 2'b11} res_sel_e;
    typedef enum logic [SEL_W-1:0] {BR_NONE = 2'b00, BR_EQ = 2'b01, BR_NE = 2'b10, BR_LTZ = 2'b11} br_kind_e;
    typedef enum logic [SEL_W-1:0] {PC_SEQ = 2'b00, PC_JUMP = 2'b01, PC_JREG = 2'b10, PC_RSVD = 2'b11} pc_mode_e;

    typedef struct packed {
        logic      wr_reg;
        logic      dst_rd;
        logic      wb_alu;
        logic      b_imm;
        logic      alu_sub;
        logic      wr_mem;
        logic_op_e logic_op;
        res_sel_e  res_sel;
        br_kind_e  br_kind;
        pc_mode_e  pc_mode;
    } ctrl_word_t;

endpackage

// File: rtl/instr_classify.sv
// Module: instr_classify
// Maps an opcode/function pair onto one instruction kind. Assumes the
// function code is meaningful only under the special opcode; anything not
// recognised yields K_BAD. Purely combinational.
module instr_classify
    import ctrl_pkg::*;
(
    input  logic [OPC_W-1:0] op_i,
    input  logic [FNC_W-1:0] fn_i,
    output instr_kind_e      kind_o
);

    instr_kind_e special_kind;

    // Purpose: name the register-format instruction from the function code.
    always_comb begin
        case (fn_i)
            FNC_ADD: special_kind = K_ADD;
            FNC_SUB: special_kind = K_SUB;
            FNC_SLT: special_kind = K_SLT;
            FNC_AND: special_kind = K_AND;
            FNC_OR:  special_kind = K_OR;
            FNC_XOR: special_kind = K_XOR;
            FNC_NOR: special_kind = K_NOR;
            FNC_JR:  special_kind = K_JR;
            default: special_kind = K_BAD;
        endcase
    end

    // Purpose: name the instruction from the opcode, deferring to the function code for the special opcode.
    always_comb begin
        case (op_i)
            OPC_SPECIAL: kind_o = special_kind;
            OPC_ADDI:    kind_o = K_ADDI;
            OPC_SLTI:    kind_o = K_SLTI;
            OPC_LUI:     kind_o = K_LUI;
            OPC_ANDI:    kind_o = K_ANDI;
            OPC_ORI:     kind_o = K_ORI;
            OPC_XORI:    kind_o = K_XORI;
            OPC_LW:      kind_o = K_LW;
            OPC_SW:      kind_o = K_SW;
            OPC_BEQ:     kind_o = K_BEQ;
            OPC_BNE:     kind_o = K_BNE;
            OPC_BLTZ:    kind_o = K_BLTZ;
            OPC_J:       kind_o = K_J;
            default:     kind_o = K_BAD;
        endcase
    end

endmodule

// File: rtl/ctrl_field_gen.sv
// Module: ctrl_field_gen
// Produces the control word for one instruction kind. Assumes K_BAD and
// every don't-care field resolve to zero, which is the safe no-effect pattern.
module ctrl_field_gen
    import ctrl_pkg::*;
(
    input  instr_kind_e kind_i,
    output ctrl_word_t  ctrl_o
);

    // Purpose: assemble every control field for the decoded kind, starting from the all-zero word.
    always_comb begin
        ctrl_o = '0;
        case (kind_i)
            K_ADD, K_SUB, K_SLT, K_AND, K_OR, K_XOR, K_NOR: begin
                ctrl_o.wr_reg = 1'b1;
                ctrl_o.dst_rd = 1'b1;
                ctrl_o.wb_alu = 1'b1;
            end
            K_ADDI, K_SLTI, K_LUI, K_ANDI, K_ORI, K_XORI: begin
                ctrl_o.wr_reg = 1'b1;
                ctrl_o.wb_alu = 1'b1;
                ctrl_o.b_imm  = 1'b1;
            end
            K_LW: begin
                ctrl_o.wr_reg = 1'b1;
                ctrl_o.b_imm  = 1'b1;
            end
            K_SW: begin
                ctrl_o.wr_mem = 1'b1;
                ctrl_o.b_imm  = 1'b1;
            end
            default: ctrl_o.wr_reg = 1'b0;
        endcase

        case (kind_i)
            K_SUB, K_SLT, K_SLTI: ctrl_o.alu_sub = 1'b1;
            default:              ctrl_o.alu_sub = 1'b0;
        endcase

        case (kind_i)
            K_OR,  K_ORI:  ctrl_o.logic_op = LOP_OR;
            K_XOR, K_XORI: ctrl_o.logic_op = LOP_XOR;
            K_NOR:         ctrl_o.logic_op = LOP_NOR;
            default:       ctrl_o.logic_op = LOP_AND;
        endcase

        case (kind_i)
            K_ADD, K_SUB, K_ADDI, K_LW, K_SW:           ctrl_o.res_sel = RES_ARITH;
            K_SLT, K_SLTI:                              ctrl_o.res_sel = RES_SLT;
            K_AND, K_OR, K_XOR, K_NOR,
            K_ANDI, K_ORI, K_XORI:                      ctrl_o.res_sel = RES_LOGIC;
            default:                                    ctrl_o.res_sel = RES_LUI;
        endcase

        case (kind_i)
            K_BEQ:   ctrl_o.br_kind = BR_EQ;
            K_BNE:   ctrl_o.br_kind = BR_NE;
            K_BLTZ:  ctrl_o.br_kind = BR_LTZ;
            default: ctrl_o.br_kind = BR_NONE;
        endcase

        case (kind_i)
            K_J:     ctrl_o.pc_mode = PC_JUMP;
            K_JR:    ctrl_o.pc_mode = PC_JREG;
            default: ctrl_o.pc_mode = PC_SEQ;
        endcase
    end

endmodule

// File: rtl/ctrl_decoder.sv
// Module: ctrl_decoder (top)
// Combinational instruction control decoder: classifies the instruction,
// then expands the kind into ten control outputs. Holds no state; outputs
// are valid once the inputs settle within the cycle.
module ctrl_decoder
    import ctrl_pkg::*;
(
    input  logic [OPC_W-1:0] op_code,
    input  logic [FNC_W-1:0] fn_code,
    output logic             wr_reg,
    output logic             dst_rd,
    output logic             wb_alu,
    output logic             b_imm,
    output logic             alu_sub,
    output logic             wr_mem,
    output logic [SEL_W-1:0] logic_op,
    output logic [SEL_W-1:0] res_sel,
    output logic [SEL_W-1:0] br_kind,
    output logic [SEL_W-1:0] pc_mode
);

    instr_kind_e kind;
    ctrl_word_t  ctrl;

    instr_classify u_classify (
        .op_i   (op_code),
        .fn_i   (fn_code),
        .kind_o (kind)
    );

    ctrl_field_gen u_fields (
        .kind_i (kind),
        .ctrl_o (ctrl)
    );

    // Purpose: fan the control word out onto the named ports.
    always_comb begin
        wr_reg   = ctrl.wr_reg;
        dst_rd   = ctrl.dst_rd;
        wb_alu   = ctrl.wb_alu;
        b_imm    = ctrl.b_imm;
        alu_sub  = ctrl.alu_sub;
        wr_mem   = ctrl.wr_mem;
        logic_op = ctrl.logic_op;
        res_sel  = ctrl.res_sel;
        br_kind  = ctrl.br_kind;
        pc_mode  = ctrl.pc_mode;
    end

endmodule

// File: rtl/ctrl_decoder_chk.sv
// Module: ctrl_decoder_chk
// Assertion checker bound into ctrl_decoder. Relates the decoded kind to the
// output ports and checks the cross-field rules. Stateless, so immediate checks.
module ctrl_decoder_chk
    import ctrl_pkg::*;
(
    input instr_kind_e      kind_i,
    input logic             wr_reg,
    input logic             wr_mem,
    input logic             b_imm,
    input logic             alu_sub,
    input logic [SEL_W-1:0] br_kind,
    input logic [SEL_W-1:0] pc_mode
);

    // Purpose: evaluate the output rules whenever any input changes.
    always_comb begin
        // R11
        pc_rsvd_chk: assert (pc_mode != 2'b11);
        // R11
        wr_excl_chk: assert (!(wr_reg && wr_mem));
        // R7
        br_nowrite_chk: assert (br_kind == 2'b00 || (!wr_reg && !wr_mem && pc_mode == 2'b00));
        // R8
        jump_nowrite_chk: assert (pc_mode == 2'b00 || (!wr_reg && !wr_mem && br_kind == 2'b00));
        // R6
        store_addr_chk: assert (!wr_mem || (b_imm && !alu_sub));
        // R9
        bad_safe_chk: assert (kind_i != K_BAD || (!wr_reg && !wr_mem && br_kind == 2'b00 && pc_mode == 2'b00));
    end

endmodule

bind ctrl_decoder ctrl_decoder_chk u_chk (
    .kind_i  (kind),
    .wr_reg  (wr_reg),
    .wr_mem  (wr_mem),
    .b_imm   (b_imm),
    .alu_sub (alu_sub),
    .br_kind (br_kind),
    .pc_mode (pc_mode)
);

// File: tb/ctrl_decoder_tb_top.sv
// Bench: directed tests, one task per scenario, each checking its own results.
module ctrl_decoder_tb_top;

    logic       clk = 1'b0;
    logic [5:0] op_code = '0;
    logic [5:0] fn_code = '0;
    logic       wr_reg, dst_rd, wb_alu, b_imm, alu_sub, wr_mem;
    logic [1:0] logic_op, res_sel, br_kind, pc_mode;
    int         checks = 0;
    int         errors = 0;
    bit         done = 1'b0;

    always #10 clk = ~clk;

    ctrl_decoder dut_i (
        .op_code (op_code), .fn_code (fn_code),
        .wr_reg (wr_reg), .dst_rd (dst_rd), .wb_alu (wb_alu), .b_imm (b_imm),
        .alu_sub (alu_sub), .wr_mem (wr_mem), .logic_op (logic_op),
        .res_sel (res_sel), .br_kind (br_kind), .pc_mode (pc_mode)
    );

    // packing: {wr_reg,dst_rd,wb_alu,b_imm,alu_sub,wr_mem,logic_op,res_sel,br_kind,pc_mode}
    function automatic logic [13:0] w(input logic [5:0] b, input logic [1:0] lo,
                                      input logic [1:0] rs, input logic [1:0] br, input logic [1:0] pc);
        return {b, lo, rs, br, pc};
    endfunction

    // expected word from the requirement text
    function automatic logic [13:0] expect_word(input logic [5:0] op, input logic [5:0] fn);
        if (op == 6'b000000) begin
            case (fn)
                6'b100000: return w(6'b111000, 2'b00, 2'b10, 2'b00, 2'b00);
                6'b100010: return w(6'b111010, 2'b00, 2'b10, 2'b00, 2'b00);
                6'b101010: return w(6'b111010, 2'b00, 2'b01, 2'b00, 2'b00);
                6'b100100: return w(6'b111000, 2'b00, 2'b11, 2'b00, 2'b00);
                6'b100101: return w(6'b111000, 2'b01, 2'b11, 2'b00, 2'b00);
                6'b100110: return w(6'b111000, 2'b10, 2'b11, 2'b00, 2'b00);
                6'b100111: return w(6'b111000, 2'b11, 2'b11, 2'b00, 2'b00);
                6'b001000: return w(6'b000000, 2'b00, 2'b00, 2'b00, 2'b10);
                default:   return '0;
            endcase
        end
        case (op)
            6'b001000: return w(6'b101100, 2'b00, 2'b10, 2'b00, 2'b00);
            6'b001010: return w(6'b101110, 2'b00, 2'b01, 2'b00, 2'b00);
            6'b001111: return w(6'b101100, 2'b00, 2'b00, 2'b00, 2'b00);
            6'b001100: return w(6'b101100, 2'b00, 2'b11, 2'b00, 2'b00);
            6'b001101: return w(6'b101100, 2'b01, 2'b11, 2'b00, 2'b00);
            6'b001110: return w(6'b101100, 2'b10, 2'b11, 2'b00, 2'b00);
            6'b100011: return w(6'b100100, 2'b00, 2'b10, 2'b00, 2'b00);
            6'b101011: return w(6'b000101, 2'b00, 2'b10, 2'b00, 2'b00);
            6'b000100: return w(6'b000000, 2'b00, 2'b00, 2'b01, 2'b00);
            6'b000101: return w(6'b000000, 2'b00, 2'b00, 2'b10, 2'b00);
            6'b000001: return w(6'b000000, 2'b00, 2'b00, 2'b11, 2'b00);
            6'b000010: return w(6'b000000, 2'b00, 2'b00, 2'b00, 2'b01);
            default:   return '0;
        endcase
    endfunction

    // drive one encoding, wait half a cycle, compare the whole output word
    task automatic apply_check(input logic [5:0] op, input logic [5:0] fn, input string req);
        logic [13:0] got, exp;
        @(posedge clk);
        op_code = op;
        fn_code = fn;
        @(negedge clk);
        got = {wr_reg, dst_rd, wb_alu, b_imm, alu_sub, wr_mem, logic_op, res_sel, br_kind, pc_mode};
        exp = expect_word(op, fn);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s op=%b fn=%b actual=%b expected=%b", req, op, fn, got, exp);
        end
    endtask

    task automatic t_idle_zero();      // R9: reset-time input (all zero) is an unlisted pair
        apply_check(6'b000000, 6'b000000, "R9");
    endtask

    task automatic t_r_arith();        // R1
        apply_check(6'b000000, 6'b100000, "R1");
        apply_check(6'b000000, 6'b100010, "R1");
        apply_check(6'b000000, 6'b101010, "R1");
    endtask

    task automatic t_r_logic();        // R2
        for (int i = 0; i < 4; i++) apply_check(6'b000000, 6'b100100 + 6'(i), "R2");
    endtask

    task automatic t_imm_arith();      // R3
        apply_check(6'b001000, 6'b000000, "R3");
        apply_check(6'b001010, 6'b000000, "R3");
        apply_check(6'b001111, 6'b000000, "R3");
    endtask

    task automatic t_imm_logic();      // R4
        for (int i = 0; i < 3; i++) apply_check(6'b001100 + 6'(i), 6'b000000, "R4");
    endtask

    task automatic t_memory();         // R5, R6
        apply_check(6'b100011, 6'b000000, "R5");
        apply_check(6'b101011, 6'b000000, "R6");
    endtask

    task automatic t_branch();         // R7
        apply_check(6'b000100, 6'b000000, "R7");
        apply_check(6'b000101, 6'b000000, "R7");
        apply_check(6'b000001, 6'b000000, "R7");
    endtask

    task automatic t_jump();           // R8
        apply_check(6'b000010, 6'b000000, "R8");
        apply_check(6'b000000, 6'b001000, "R8");
    endtask

    task automatic t_fn_ignored();     // R10: special-opcode function codes under other opcodes
        logic [5:0] fns [4] = '{6'b100000, 6'b100010, 6'b001000, 6'b111111};
        for (int o = 1; o < 64; o++)
            for (int f = 0; f < 4; f++) apply_check(6'(o), fns[f], "R10");
    endtask

    task automatic t_sweep();          // R9, R11: every opcode/function pair
        for (int o = 0; o < 64; o++)
            for (int f = 0; f < 64; f++) begin
                apply_check(6'(o), 6'(f), "R9");
                checks++;
                if (pc_mode == 2'b11 || (wr_reg && wr_mem) ||
                    ((br_kind != 2'b00 || pc_mode != 2'b00) && (wr_reg || wr_mem))) begin
                    errors++;
                    $display("FAIL R11 op=%0d fn=%0d actual=%b/%b/%b/%b expected=legal mix",
                             o, f, wr_reg, wr_mem, br_kind, pc_mode);
                end
            end
    endtask

    initial begin
        t_idle_zero();
        t_r_arith();
        t_r_logic();
        t_imm_arith();
        t_imm_logic();
        t_memory();
        t_branch();
        t_jump();
        t_fn_ignored();
        t_sweep();
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule